// File: doc/BRIEF.md
# End-to-End Credit Flow Controller

This block sits in a network interface and keeps a source from overrunning the receive queue of a remote interface. The block tracks that queue across the whole network path. It does not rely on per-hop credit wires. On the source side, a space counter starts at the depth of the remote queue. Each injected flit lowers the counter by one. Injection is refused while the counter reads zero.

On the destination side, a pending-credit counter goes up by one each time the local core takes an entry out of the receive queue. Credits do not travel as separate messages. They ride back in the credit field of headers that flow in the reverse direction. When a header is emitted, the field is loaded from the pending count and that amount is removed from the count. When a header arrives, its field is added back to the source's space. Longer packets leave more time between headers, so each header can return more credits.

Top module: `e2e_credit_flow`

## Requirements
- R1: After reset, the space count equals DEPTH (8 by default), srcReady is 1, the pending credit count is 0 and hdrOutCredit is 0.
- R2: A cycle with srcValid high while the space count is nonzero injects a flit: the space count falls by one at the next clock edge.
- R3: srcReady is 1 exactly when the space count is nonzero. With the space count at zero, srcValid leaves the space count unchanged.
- R4: Each cycle with dstConsume high raises the pending credit count by one, saturating at its maximum. hdrOutCredit always shows the pending count.
- R5: A cycle with hdrOutEmit high subtracts the hdrOutCredit value from the pending count. A consume in the same cycle is added to the new total.
- R6: The credit field is 4 bits wide. A pending count above 15 shows as 15 on hdrOutCredit, and the remainder stays pending after the emit.
- R7: A cycle with hdrInValid high adds hdrInCredit to the space count.
- R8: When an injection and an incoming header fall in the same cycle, the space count changes by the net amount.
- R9: The space count never exceeds DEPTH. A return that would pass DEPTH leaves the count at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcValid | input | 1 | Source wants to inject a flit |
| srcReady | output | 1 | Injection allowed (space remains) |
| hdrInValid | input | 1 | A header arrives from the reverse path |
| hdrInCredit | input | 4 | Credit field of the arriving header |
| dstConsume | input | 1 | Local core removed one receive-queue entry |
| hdrOutEmit | input | 1 | A header leaves this cycle toward the remote source |
| hdrOutCredit | output | 4 | Credit field for the outgoing header |
| spaceCount | output | 4 | Remote free space seen by the source |
| pendCredit | output | 8 | Credits waiting to be returned |

## Verification
The hardest cases to reach are the ones where several events land in the same cycle. One is an emit together with a consume. Another is an injection together with an arriving header. A third is a pending count large enough that it must span two headers. The directed tasks first push the space count to zero, then drive the coincident strobes in one cycle. They also build up twenty pending credits before emitting, so that both the split return and the DEPTH clamp can be seen on the ports.

// File: rtl/e2e_credit_pkg.sv
package e2e_credit_pkg;
  typedef struct packed {
    logic sendFire;
    logic creditIn;
    logic consume;
    logic emit;
  } ctrl_strobe_t;
endpackage

// File: rtl/e2e_credit_ctrl.sv
module e2e_credit_ctrl
  import e2e_credit_pkg::*;
(
  input  logic         srcValid,
  input  logic         hdrInValid,
  input  logic         dstConsume,
  input  logic         hdrOutEmit,
  input  logic         spaceAvail,
  output logic         srcReady,
  output ctrl_strobe_t strobes
);
  always_comb begin
    srcReady         = spaceAvail;
    strobes.sendFire = srcValid && spaceAvail;
    strobes.creditIn = hdrInValid;
    strobes.consume  = dstConsume;
    strobes.emit     = hdrOutEmit;
  end
endmodule

// File: rtl/e2e_credit_dp.sv
module e2e_credit_dp
  import e2e_credit_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int FIELD_W = 4,
  parameter int PEND_W  = 8,
  localparam int SPACE_W = $clog2(DEPTH + 1)
)(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobes,
  input  logic [FIELD_W-1:0] hdrInCredit,
  output logic [SPACE_W-1:0] spaceCount,
  output logic               spaceAvail,
  output logic [PEND_W-1:0]  pendCount,
  output logic [FIELD_W-1:0] hdrOutCredit
);
  localparam int SUM_W = ((SPACE_W > FIELD_W) ? SPACE_W : FIELD_W) + 1;
  localparam logic [PEND_W-1:0] FIELD_MAX = PEND_W'((1 << FIELD_W) - 1);
  localparam logic [PEND_W-1:0] PEND_MAX  = '1;

  logic [SUM_W-1:0]   spaceSum;
  logic [SPACE_W-1:0] spaceNext;
  logic [PEND_W-1:0]  pendBase, pendNext;

  always_comb begin
    hdrOutCredit = (pendCount > FIELD_MAX) ? FIELD_W'(FIELD_MAX) : FIELD_W'(pendCount);
    spaceAvail   = (spaceCount != '0);
    spaceSum = SUM_W'(spaceCount)
             + (strobes.creditIn ? SUM_W'(hdrInCredit) : '0)
             - SUM_W'(strobes.sendFire);
    spaceNext = (spaceSum > SUM_W'(DEPTH)) ? SPACE_W'(DEPTH) : SPACE_W'(spaceSum);
    pendBase  = strobes.emit ? pendCount - PEND_W'(hdrOutCredit) : pendCount;
    pendNext  = (strobes.consume && pendBase != PEND_MAX) ? pendBase + 1'b1 : pendBase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spaceCount <= SPACE_W'(DEPTH);
      pendCount  <= '0;
    end else begin
      spaceCount <= spaceNext;
      pendCount  <= pendNext;
    end
  end

  // R9
  space_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    spaceCount <= SPACE_W'(DEPTH));

  // R3
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spaceCount == '0 && !strobes.creditIn) |=> spaceCount == '0);

  // R2
  send_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sendFire && !strobes.creditIn) |=> spaceCount == $past(spaceCount) - 1'b1);

  // R4
  consume_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.consume && !strobes.emit && pendCount != PEND_MAX)
      |=> pendCount == $past(pendCount) + 1'b1);

  // R5
  emit_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.emit && !strobes.consume)
      |=> pendCount == $past(pendCount) - PEND_W'($past(hdrOutCredit)));
endmodule

// File: rtl/e2e_credit_flow.sv
module e2e_credit_flow
  import e2e_credit_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int FIELD_W = 4,
  parameter int PEND_W  = 8,
  localparam int SPACE_W = $clog2(DEPTH + 1)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               srcValid,
  output logic               srcReady,
  input  logic               hdrInValid,
  input  logic [FIELD_W-1:0] hdrInCredit,
  input  logic               dstConsume,
  input  logic               hdrOutEmit,
  output logic [FIELD_W-1:0] hdrOutCredit,
  output logic [SPACE_W-1:0] spaceCount,
  output logic [PEND_W-1:0]  pendCredit
);
  ctrl_strobe_t strobes;
  logic spaceAvail;

  e2e_credit_ctrl u_ctrl (
    .srcValid(srcValid), .hdrInValid(hdrInValid), .dstConsume(dstConsume),
    .hdrOutEmit(hdrOutEmit), .spaceAvail(spaceAvail),
    .srcReady(srcReady), .strobes(strobes)
  );

  e2e_credit_dp #(.DEPTH(DEPTH), .FIELD_W(FIELD_W), .PEND_W(PEND_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hdrInCredit(hdrInCredit),
    .spaceCount(spaceCount), .spaceAvail(spaceAvail),
    .pendCount(pendCredit), .hdrOutCredit(hdrOutCredit)
  );
endmodule

// File: tb/e2e_credit_flow_bench.sv
module e2e_credit_flow_bench;
  logic clk = 0, rstN = 0;
  logic srcValid = 0, hdrInValid = 0, dstConsume = 0, hdrOutEmit = 0;
  logic [3:0] hdrInCredit = 0;
  logic srcReady;
  logic [3:0] hdrOutCredit, spaceCount;
  logic [7:0] pendCredit;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  e2e_credit_flow u_e2e_credit_flow (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcReady(srcReady),
    .hdrInValid(hdrInValid), .hdrInCredit(hdrInCredit), .dstConsume(dstConsume),
    .hdrOutEmit(hdrOutEmit), .hdrOutCredit(hdrOutCredit),
    .spaceCount(spaceCount), .pendCredit(pendCredit)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(logic s, logic h, logic [3:0] c, logic k, logic e);
    srcValid = s; hdrInValid = h; hdrInCredit = c; dstConsume = k; hdrOutEmit = e;
    @(posedge clk); #2;
    srcValid = 0; hdrInValid = 0; hdrInCredit = 0; dstConsume = 0; hdrOutEmit = 0;
  endtask

  task automatic t_reset;
    chk("R1 space", spaceCount, 8); chk("R1 ready", srcReady, 1);
    chk("R1 pend", pendCredit, 0);  chk("R1 field", hdrOutCredit, 0);
  endtask

  task automatic t_send;
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0);
    chk("R2 space after 3", spaceCount, 5);
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0);
    chk("R2 space drained", spaceCount, 0);
    chk("R3 ready low", srcReady, 0);
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    chk("R3 blocked send", spaceCount, 0);
  endtask

  task automatic t_return;
    cyc(0, 1, 4'd3, 0, 0);
    chk("R7 return 3", spaceCount, 3); chk("R3 ready high", srcReady, 1);
    cyc(1, 1, 4'd2, 0, 0);
    chk("R8 net send+return", spaceCount, 4);
    cyc(1, 1, 4'd1, 0, 0);
    chk("R8 net zero", spaceCount, 4);
    cyc(0, 1, 4'd15, 0, 0);
    chk("R9 clamp", spaceCount, 8);
    cyc(0, 1, 4'd1, 0, 0);
    chk("R9 at depth", spaceCount, 8);
  endtask

  task automatic t_credit;
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 0);
    chk("R4 pend 5", pendCredit, 5); chk("R4 field 5", hdrOutCredit, 5);
    cyc(0, 0, 0, 1, 1);
    chk("R5 emit+consume", pendCredit, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R5 emit clears", pendCredit, 0); chk("R5 field 0", hdrOutCredit, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R5 emit at zero", pendCredit, 0);
  endtask

  task automatic t_split;
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 1, 0);
    chk("R4 pend 20", pendCredit, 20);
    chk("R6 field capped", hdrOutCredit, 15);
    cyc(0, 0, 0, 0, 1);
    chk("R6 remainder", pendCredit, 5); chk("R6 next field", hdrOutCredit, 5);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk); #2; rstN = 1;
        t_reset(); t_send(); t_return(); t_credit(); t_split();
      end
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule